// File: doc/BRIEF.md
# Embedded-Sync Video Timing Decoder

This block takes an interleaved 4:2:2 YCbCr word stream (Cb, Y, Cr, Y, one word per pixel clock) and recovers line and frame timing from the timing reference codes carried inside the stream. It produces separate horizontal sync, vertical sync, field and active-video outputs, with the video words aligned to them. A four-word window looks ahead at the stream, so every word is classified before it leaves the block. Outputs always lag the input by a fixed four clocks.

Two configuration inputs select the operating mode, and both are expected to stay static while video flows.

- `cfg_emb_in` states whether the input carries embedded codes.
- With embedded input, `cfg_code_out` chooses between two outputs:
  - the unchanged code-bearing stream, or
  - separate-sync output, where the four code words are replaced by blanking values.
- With separate-sync input, the block is a plain aligned bypass and ignores any request for code output.

Pixel values in the active region are never clipped, whether the source uses limited or full range.

Top module: `ycc_sync_extract`

## Requirements
- R1: A word sampled on clock edge n appears on `vid_out` after edge n+4 in every mode, except where R7 substitutes it.
- R2: A timing code is the four-word run all-ones, zero, zero, XY. In XY, bit 7 must be 1, F is bit 6, V is bit 5 and H is bit 4 (H=1 end of line, H=0 start of line). The protection bits are bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H.
- R3: With embedded input and `cfg_code_out`=1, `vid_out` repeats the input unchanged, codes included, and `hs_out`, `vs_out`, `fld_out` and `act_out` stay low.
- R4: In separate-sync mode, `hs_out` rises with the output cycle of an end-of-line code's first word and falls with the output cycle of the next start-of-line code's first word.
- R5: In separate-sync mode, `vs_out` and `fld_out` take the V and F flags of each accepted code in the output cycle of that code's first word, and hold them until the next accepted code.
- R6: `act_out` is high only for the words after the XY word of a start-of-line code with V=0, up to but not including the first word of the next end-of-line code. It stays low during codes and after a start-of-line code with V=1.
- R7: In separate-sync mode, the four words of an accepted code are output as 0x80, 0x10, 0x80, 0x10.
- R8: A code whose XY word breaks the R2 rules is ignored. Sync and field outputs hold their values, and its four words pass through unchanged.
- R9: With `cfg_emb_in`=0, `cfg_code_out` has no effect. Data, hsync, vsync and field are delayed by four clocks, codes in the data are not interpreted, and `act_out` is high exactly when the delayed hsync and vsync are both low.
- R10: In the active region, every word value (for example 0x01, 0xFE, 0xF0, 0x7F) is output unchanged.
- R11: While `rst` is high, all outputs are zero after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_emb_in | input | 1 | 1: input carries embedded timing codes; 0: separate sync inputs |
| cfg_code_out | input | 1 | With embedded input, 1 passes the code stream out unchanged |
| vid_in | input | DATA_W | Interleaved YCbCr input word |
| hs_in | input | 1 | Horizontal sync for separate-sync input |
| vs_in | input | 1 | Vertical sync for separate-sync input |
| fld_in | input | 1 | Field flag for separate-sync input |
| vid_out | output | DATA_W | Aligned output word |
| hs_out | output | 1 | Horizontal sync output |
| vs_out | output | 1 | Vertical sync output |
| fld_out | output | 1 | Field output |
| act_out | output | 1 | Active video marker |

## Verification
Every output reflects the input word and sync sampled exactly four rising edges earlier. This includes the sync and active flags tied to a code, because they are set in the output cycle of the code's first word. The bench drives one word per clock and records all outputs at each falling edge into a history indexed by input word number. Each check then reads entry k+4 for the word driven as number k, so no check depends on when the recording happens relative to the clock edge.

// File: rtl/ycc_sync_pkg.sv
package ycc_sync_pkg;

  // number of words in a timing code: preamble of three plus the flag word
  localparam int CODE_LEN = 4;

  typedef struct packed {
    logic hs;
    logic vs;
    logic fld;
  } sync_t;

  // flag word consistency: leading one plus four parity bits over F, V, H
  function automatic logic prot_ok(input logic lead, input logic f, input logic v,
                                   input logic h, input logic [3:0] p);
    return lead & (p[3] == (v ^ h)) & (p[2] == (f ^ h)) &
           (p[1] == (f ^ v)) & (p[0] == (f ^ v ^ h));
  endfunction

endpackage

// File: rtl/ycc_tap_line.sv
module ycc_tap_line
  import ycc_sync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAPS   = CODE_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  sync_t             sin,
  output logic [DATA_W-1:0] dtap [TAPS],
  output sync_t             stap [TAPS]
);
  // tap 0 holds the newest word, tap TAPS-1 the oldest
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          dtap[i] <= '0;
          stap[i] <= '0;
        end else begin
          dtap[i] <= din;
          stap[i] <= sin;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          dtap[i] <= '0;
          stap[i] <= '0;
        end else begin
          dtap[i] <= dtap[i-1];
          stap[i] <= stap[i-1];
        end
      end
    end
  end

  // cycles since reset, saturating at the window depth (used by the check)
  localparam int FILL_W = $clog2(TAPS + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(TAPS);
  logic [FILL_W-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else if (fill != FILL_MAX) fill <= fill + 1'b1;
  end

  // R1: the oldest tap is the input from exactly TAPS edges before
  a_r1_tap_delay: assert property (@(posedge clk) disable iff (rst)
    (fill == FILL_MAX) |-> (dtap[TAPS-1] == $past(din, TAPS)));

endmodule

// File: rtl/ycc_trs_find.sv
module ycc_trs_find
  import ycc_sync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] dtap [CODE_LEN],
  output logic              hit,
  output logic              f,
  output logic              v,
  output logic              h
);
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] xy;
  logic              preamble;

  always_comb begin
    xy       = dtap[0];
    preamble = (dtap[CODE_LEN-1] == ONES) && (dtap[CODE_LEN-2] == ZERO) &&
               (dtap[CODE_LEN-3] == ZERO);
    f        = xy[DATA_W-2];
    v        = xy[DATA_W-3];
    h        = xy[DATA_W-4];
    hit      = preamble & prot_ok(xy[DATA_W-1], xy[DATA_W-2], xy[DATA_W-3],
                                  xy[DATA_W-4], xy[DATA_W-5 -: 4]);
  end

endmodule

// File: rtl/ycc_sync_track.sv
module ycc_sync_track
  import ycc_sync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emb_in,
  input  logic              code_out,
  input  logic              hit,
  input  logic              f,
  input  logic              v,
  input  logic              h,
  input  logic [DATA_W-1:0] word,
  input  sync_t             sync_in,
  output logic [DATA_W-1:0] out_data,
  output logic              out_hs,
  output logic              out_vs,
  output logic              out_fld,
  output logic              out_act
);
  localparam logic [DATA_W-1:0] BLANK_C = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] BLANK_Y = {3'b000, 1'b1, {(DATA_W-4){1'b0}}};
  localparam int SKIP_W = $clog2(CODE_LEN);
  localparam logic [SKIP_W-1:0] SKIP_MAX = SKIP_W'(CODE_LEN - 1);
  localparam logic [SKIP_W-1:0] SKIP_MID = SKIP_W'(CODE_LEN - 2);

  logic [SKIP_W-1:0] skip;     // code words still to leave after the first
  logic              in_act;   // between a visible start-of-line and end-of-line
  logic              take;
  logic              chroma_slot;

  assign take        = emb_in & hit & (skip == '0);
  assign chroma_slot = take | (skip == SKIP_MID);

  always_ff @(posedge clk) begin
    if (rst) begin
      skip     <= '0;
      in_act   <= 1'b0;
      out_data <= '0;
      out_hs   <= 1'b0;
      out_vs   <= 1'b0;
      out_fld  <= 1'b0;
      out_act  <= 1'b0;
    end else begin
      if (take) skip <= SKIP_MAX;
      else if (skip != '0) skip <= skip - 1'b1;

      if (!emb_in) in_act <= 1'b0;
      else if (take) in_act <= ~h & ~v;

      if (!emb_in) begin
        out_data <= word;
        out_hs   <= sync_in.hs;
        out_vs   <= sync_in.vs;
        out_fld  <= sync_in.fld;
        out_act  <= ~sync_in.hs & ~sync_in.vs;
      end else if (code_out) begin
        out_data <= word;
        out_hs   <= 1'b0;
        out_vs   <= 1'b0;
        out_fld  <= 1'b0;
        out_act  <= 1'b0;
      end else begin
        if (take) begin
          out_hs  <= h;
          out_vs  <= v;
          out_fld <= f;
        end
        out_act  <= in_act & ~take & (skip == '0);
        out_data <= (take || skip != '0) ? (chroma_slot ? BLANK_C : BLANK_Y) : word;
      end
    end
  end

  // R6: active video never overlaps horizontal or vertical sync
  a_r6_act_excl_sync: assert property (@(posedge clk) disable iff (rst)
    out_act |-> (!out_hs && !out_vs));

  // R8: without an accepted code the recovered sync state does not move
  a_r8_hold_sync: assert property (@(posedge clk) disable iff (rst)
    (emb_in && !code_out && !take) |=> $stable({out_hs, out_vs, out_fld}));

  // R3: code-stream output mode is a straight copy with no timing flags
  a_r3_code_copy: assert property (@(posedge clk) disable iff (rst)
    (emb_in && code_out) |=> ((out_data == $past(word)) && !out_act && !out_hs));

endmodule

// File: rtl/ycc_sync_extract.sv
module ycc_sync_extract
  import ycc_sync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_emb_in,
  input  logic              cfg_code_out,
  input  logic [DATA_W-1:0] vid_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              fld_in,
  output logic [DATA_W-1:0] vid_out,
  output logic              hs_out,
  output logic              vs_out,
  output logic              fld_out,
  output logic              act_out
);
  logic [DATA_W-1:0] dtap [CODE_LEN];
  sync_t             stap [CODE_LEN];
  sync_t             sync_now;
  logic              hit, f_flag, v_flag, h_flag;

  assign sync_now = '{hs: hs_in, vs: vs_in, fld: fld_in};

  ycc_tap_line #(.DATA_W(DATA_W), .TAPS(CODE_LEN)) u_taps (
    .clk  (clk),
    .rst  (rst),
    .din  (vid_in),
    .sin  (sync_now),
    .dtap (dtap),
    .stap (stap)
  );

  ycc_trs_find #(.DATA_W(DATA_W)) u_find (
    .dtap (dtap),
    .hit  (hit),
    .f    (f_flag),
    .v    (v_flag),
    .h    (h_flag)
  );

  ycc_sync_track #(.DATA_W(DATA_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .emb_in   (cfg_emb_in),
    .code_out (cfg_code_out),
    .hit      (hit),
    .f        (f_flag),
    .v        (v_flag),
    .h        (h_flag),
    .word     (dtap[CODE_LEN-1]),
    .sync_in  (stap[CODE_LEN-1]),
    .out_data (vid_out),
    .out_hs   (hs_out),
    .out_vs   (vs_out),
    .out_fld  (fld_out),
    .out_act  (act_out)
  );

endmodule

// File: tb/test_ycc_sync_extract.sv
module test_ycc_sync_extract;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_emb_in = 1'b1;
  logic       cfg_code_out = 1'b0;
  logic [7:0] vid_in = 8'h10;
  logic       hs_in = 1'b0, vs_in = 1'b0, fld_in = 1'b0;
  logic [7:0] vid_out;
  logic       hs_out, vs_out, fld_out, act_out;

  always #2ns clk = ~clk;

  ycc_sync_extract #(.DATA_W(8)) i_ycc_sync_extract (
    .clk(clk), .rst(rst), .cfg_emb_in(cfg_emb_in), .cfg_code_out(cfg_code_out),
    .vid_in(vid_in), .hs_in(hs_in), .vs_in(vs_in), .fld_in(fld_in),
    .vid_out(vid_out), .hs_out(hs_out), .vs_out(vs_out), .fld_out(fld_out),
    .act_out(act_out)
  );

  int nchk = 0, nerr = 0, n = 0;
  bit done = 0;
  logic [7:0] o_d  [1024];
  logic       o_hs [1024], o_vs [1024], o_fl [1024], o_ac [1024];

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R2 flag word layout
  function automatic logic [7:0] mkxy(logic f, logic v, logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic put(logic [7:0] b, logic h = 1'b0, logic v = 1'b0, logic fl = 1'b0);
    vid_in = b; hs_in = h; vs_in = v; fld_in = fl;
    @(posedge clk); @(negedge clk);
    o_d[n] = vid_out; o_hs[n] = hs_out; o_vs[n] = vs_out; o_fl[n] = fld_out; o_ac[n] = act_out;
    n++;
  endtask

  task automatic put_code(logic f, logic v, logic h);
    put(8'hFF); put(8'h00); put(8'h00); put(mkxy(f, v, h));
  endtask

  task automatic flush(int k);
    for (int i = 0; i < k; i++) put(8'h10);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 data", vid_out, 0); chk("R11 hs", hs_out, 0); chk("R11 vs", vs_out, 0);
    chk("R11 fld", fld_out, 0);  chk("R11 act", act_out, 0);
    rst = 1'b0;
  endtask

  task automatic t_line();
    logic [7:0] act_vals [8] = '{8'h01, 8'hFE, 8'hEB, 8'h10, 8'hF0, 8'h80, 8'h7F, 8'h02};
    logic [7:0] blank [4] = '{8'h80, 8'h10, 8'h80, 8'h10};
    int i0, i1, i2, i3;
    cfg_emb_in = 1'b1; cfg_code_out = 1'b0;
    flush(4);
    i0 = n; put_code(0, 0, 1);
    for (int j = 0; j < 4; j++) put(blank[j]);
    i1 = n; put_code(0, 0, 0);
    i2 = n; for (int j = 0; j < 8; j++) put(act_vals[j]);
    i3 = n; put_code(0, 0, 1);
    flush(5);
    chk("R4 hs low before end code", o_hs[i0+3], 0);
    chk("R4 hs rises at end code", o_hs[i0+4], 1);
    chk("R6 act low on code", o_ac[i0+4], 0);
    for (int j = 0; j < 4; j++) chk("R7 code word blanked", o_d[i0+4+j], blank[j]);
    for (int j = 0; j < 4; j++) chk("R1 blanking word delay", o_d[i0+8+j], blank[j]);
    chk("R4 hs high in blanking", o_hs[i0+10], 1);
    chk("R4 hs falls at start code", o_hs[i1+4], 0);
    chk("R7 start code word0", o_d[i1+4], 8'h80);
    chk("R7 start code word3", o_d[i1+7], 8'h10);
    chk("R6 act low on flag word", o_ac[i1+7], 0);
    for (int j = 0; j < 8; j++) begin
      chk("R10 active word unchanged", o_d[i2+4+j], act_vals[j]);
      chk("R6 act high in line", o_ac[i2+4+j], 1);
    end
    chk("R6 act low at end code", o_ac[i3+4], 0);
    chk("R4 hs high at end code", o_hs[i3+4], 1);
    chk("R5 vs low", o_vs[i3+4], 0);
    chk("R5 fld low", o_fl[i3+4], 0);
  endtask

  task automatic t_vblank();
    int i4;
    i4 = n; put_code(1, 1, 0);
    put(8'h55); put(8'hAA); put(8'h55); put(8'hAA);
    flush(4);
    chk("R5 vs follows V", o_vs[i4+4], 1);
    chk("R5 fld follows F", o_fl[i4+4], 1);
    chk("R5 vs before code", o_vs[i4+3], 0);
    chk("R4 hs falls", o_hs[i4+4], 0);
    chk("R6 act low in vblank", o_ac[i4+8], 0);
    chk("R6 act low in vblank", o_ac[i4+10], 0);
    chk("R1 vblank word", o_d[i4+9], 8'hAA);
  endtask

  task automatic t_badcode();
    int i5;
    logic [7:0] bad;
    bad = mkxy(0, 0, 1) ^ 8'h01;
    i5 = n; put(8'hFF); put(8'h00); put(8'h00); put(bad);
    flush(5);
    chk("R8 raw word0", o_d[i5+4], 8'hFF);
    chk("R8 raw word1", o_d[i5+5], 8'h00);
    chk("R8 raw word3", o_d[i5+7], bad);
    chk("R8 hs held", o_hs[i5+7], 0);
    chk("R8 hs held", o_hs[i5+8], 0);
    chk("R8 vs held", o_vs[i5+8], 1);
    chk("R8 fld held", o_fl[i5+8], 1);
  endtask

  task automatic t_codeout();
    int i6;
    cfg_code_out = 1'b1;
    flush(5);
    i6 = n; put_code(0, 0, 1); put(8'h33); put(8'h44);
    flush(5);
    chk("R3 word0", o_d[i6+4], 8'hFF);
    chk("R3 word2", o_d[i6+6], 8'h00);
    chk("R3 flag word", o_d[i6+7], 8'h9D);
    chk("R3 data", o_d[i6+9], 8'h44);
    chk("R3 hs low", o_hs[i6+4], 0);
    chk("R3 vs low", o_vs[i6+8], 0);
    chk("R3 fld low", o_fl[i6+8], 0);
    chk("R3 act low", o_ac[i6+8], 0);
  endtask

  task automatic t_bypass();
    logic [7:0] d [6] = '{8'h20, 8'hFF, 8'h00, 8'h00, 8'h9D, 8'h30};
    logic       hh [6] = '{1, 0, 0, 0, 0, 1};
    logic       vv [6] = '{0, 0, 0, 1, 0, 1};
    logic       ff [6] = '{0, 0, 1, 1, 0, 0};
    int i7;
    cfg_emb_in = 1'b0; cfg_code_out = 1'b1;
    flush(5);
    i7 = n;
    for (int j = 0; j < 6; j++) put(d[j], hh[j], vv[j], ff[j]);
    flush(5);
    for (int j = 0; j < 6; j++) begin
      chk("R9 data", o_d[i7+4+j], d[j]);
      chk("R9 hs", o_hs[i7+4+j], hh[j]);
      chk("R9 vs", o_vs[i7+4+j], vv[j]);
      chk("R9 fld", o_fl[i7+4+j], ff[j]);
      chk("R9 act", o_ac[i7+4+j], (!hh[j] && !vv[j]) ? 1 : 0);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_line();
    t_vblank();
    t_badcode();
    t_codeout();
    t_bypass();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule